// File: doc/BRIEF.md
# Pixel Sample Timing and Clamp Control

This block turns the two external pixel timing pins of an imaging front end into a pair of clean internal controls clocked by the master clock: a video-sample pulse for the sampling and conversion path, and a close command for the reset-level clamp switch. Both pins are first brought into the master clock domain through a two-flop synchroniser, and both outputs are registered, so every path has the same fixed latency.

In the normal timing mode the video-sample pin is forwarded unchanged. In the compatibility mode the block can instead watch for one chosen edge of that pin, rising or falling, and emit a one-cycle internal pulse a programmable number of clock periods later. A new edge that arrives while a delayed pulse is still waiting restarts the delay count. The clamp command follows the reset-sample pin alone, or the AND of both pins, or a register bit when the analogue channels are being cycled automatically. In the compatibility mode the clamp fires on every pixel, together with the internal sample pulse.

Configuration bits are treated as static register values. They are changed only while the pins are idle.

Top module: `pix_sample_timing`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sample_pulse` and `clamp_close` are 0.
- R2: Unless both `cfg_legacy` and `cfg_det_en` are 1, `sample_pulse` equals `vsmp_pin` as it was sampled three clock edges earlier (two synchroniser stages plus the output register).
- R3: With `cfg_legacy`=1 and `cfg_det_en`=1, the edge selected by `cfg_rise_sel` produces exactly one `sample_pulse` cycle, and a steady pin gives none. `cfg_rise_sel`=1 selects rising edges and `cfg_rise_sel`=0 selects falling edges. An edge of the other polarity gives no pulse.
- R4: `cfg_rise_sel` has no effect outside edge-detect mode.
- R5: In edge-detect mode, take a pin change set up before clock edge k. With the delay code D in `cfg_delay`, `sample_pulse` is high for the one cycle after edge k+2+D.
- R6: In edge-detect mode, a selected edge that arrives while a delayed pulse is pending discards that pulse and restarts the delay from the new edge. Only one pulse results.
- R7: Outside legacy mode, with `cfg_clamp_en`=1, `cfg_autocycle`=0 and `cfg_clamp_and`=0, `clamp_close` equals `rsmp_pin` delayed by three edges.
- R8: Outside legacy mode, with `cfg_clamp_en`=1, `cfg_autocycle`=0 and `cfg_clamp_and`=1, `clamp_close` is the AND of `rsmp_pin` and `vsmp_pin`, delayed by three edges.
- R9: Outside legacy mode, with `cfg_clamp_en`=1 and `cfg_autocycle`=1, `clamp_close` equals `cfg_clamp_force` of the previous cycle, and `rsmp_pin` has no effect.
- R10: Outside legacy mode, with `cfg_clamp_en`=0, `clamp_close` stays 0 whatever the pins and the other clamp bits are.
- R11: With `cfg_legacy`=1, `clamp_close` equals `sample_pulse` in every cycle, whatever `cfg_clamp_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| vsmp_pin | input | 1 | Asynchronous video-sample timing pin |
| rsmp_pin | input | 1 | Asynchronous reset-sample timing pin |
| cfg_legacy | input | 1 | Compatibility timing mode |
| cfg_det_en | input | 1 | Enables edge-detect pulse generation (legacy mode only) |
| cfg_rise_sel | input | 1 | 1: rising edge, 0: falling edge triggers the pulse |
| cfg_delay | input | DLY_W (3) | Pulse delay in clock periods after the detected edge |
| cfg_clamp_en | input | 1 | Reset-level clamp enable (outside legacy mode) |
| cfg_clamp_and | input | 1 | 1: clamp on RSMP AND VSMP, 0: clamp on RSMP |
| cfg_autocycle | input | 1 | Channel auto-cycling active; clamp taken from register bit |
| cfg_clamp_force | input | 1 | Clamp command used during auto-cycling |
| sample_pulse | output | 1 | Internal video-sample pulse |
| clamp_close | output | 1 | Clamp switch close command |

## Verification
The hardest case to reach is the retrigger in R6. A second selected edge has to land while the counter of a first edge is still running, so the pin must fall and rise again within fewer cycles than the programmed delay. The bench applies cycle-by-cycle pin patterns on the falling clock edge, with the delay set to 4. It checks that exactly one pulse appears, at the position measured from the second edge and not from the first. A design that does not restart the count would instead show two pulses, or one pulse two cycles early.

// File: rtl/pst_pkg.sv
package pst_pkg;

  // Source that drives the clamp switch command
  typedef enum logic [2:0] {
    CS_OFF   = 3'd0,
    CS_RSMP  = 3'd1,
    CS_AND   = 3'd2,
    CS_REG   = 3'd3,
    CS_PULSE = 3'd4
  } clamp_src_e;

  // Synchronised pin pair
  typedef struct packed {
    logic vsmp;
    logic rsmp;
  } pin_pair_t;

endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pst_edge_pulse.sv
module pst_edge_pulse #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sig,
  input  logic             rise_sel,
  input  logic [DLY_W-1:0] delay,
  output logic             fire
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             sig_q;
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;
  logic             hit;

  // Selected-polarity transition of the synchronised pin
  always_comb begin
    if (rise_sel) hit = en & sig & ~sig_q;
    else          hit = en & ~sig & sig_q;
  end

  // A fresh edge overrides any pending count (restart)
  always_comb begin
    if (hit) fire = (delay == '0);
    else     fire = en & pend_q & (cnt_q == ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sig_q <= sig;
      if (!en) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else if (hit) begin
        pend_q <= (delay != '0);
        cnt_q  <= delay;
      end else if (pend_q) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pst_clamp_sel.sv
module pst_clamp_sel
  import pst_pkg::*;
(
  input  logic legacy,
  input  logic clamp_en,
  input  logic autocycle,
  input  logic and_mode,
  input  logic force_bit,
  input  logic rsmp,
  input  logic vsmp,
  input  logic int_pulse,
  output logic close
);

  clamp_src_e src;

  // Priority: legacy, enable, auto-cycle, gating mode
  always_comb begin
    if (legacy)         src = CS_PULSE;
    else if (!clamp_en) src = CS_OFF;
    else if (autocycle) src = CS_REG;
    else if (and_mode)  src = CS_AND;
    else                src = CS_RSMP;
  end

  always_comb begin
    unique case (src)
      CS_PULSE: close = int_pulse;
      CS_REG:   close = force_bit;
      CS_AND:   close = rsmp & vsmp;
      CS_RSMP:  close = rsmp;
      default:  close = 1'b0;
    endcase
  end

endmodule

// File: rtl/pix_sample_timing.sv
module pix_sample_timing
  import pst_pkg::*;
#(
  parameter int DLY_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vsmp_pin,
  input  logic             rsmp_pin,
  input  logic             cfg_legacy,
  input  logic             cfg_det_en,
  input  logic             cfg_rise_sel,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             cfg_clamp_en,
  input  logic             cfg_clamp_and,
  input  logic             cfg_autocycle,
  input  logic             cfg_clamp_force,
  output logic             sample_pulse,
  output logic             clamp_close
);

  localparam int PIN_W = $bits(pin_pair_t);

  pin_pair_t pins_async;
  pin_pair_t pins_s;
  logic      det_mode;
  logic      det_fire;
  logic      int_pulse;
  logic      clamp_nxt;

  assign pins_async.vsmp = vsmp_pin;
  assign pins_async.rsmp = rsmp_pin;
  assign det_mode        = cfg_legacy & cfg_det_en;

  pst_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pins_async),
    .q_sync  (pins_s)
  );

  pst_edge_pulse #(
    .DLY_W (DLY_W)
  ) u_edge (
    .clk      (clk),
    .rst      (rst),
    .en       (det_mode),
    .sig      (pins_s.vsmp),
    .rise_sel (cfg_rise_sel),
    .delay    (cfg_delay),
    .fire     (det_fire)
  );

  assign int_pulse = det_mode ? det_fire : pins_s.vsmp;

  pst_clamp_sel u_clamp (
    .legacy    (cfg_legacy),
    .clamp_en  (cfg_clamp_en),
    .autocycle (cfg_autocycle),
    .and_mode  (cfg_clamp_and),
    .force_bit (cfg_clamp_force),
    .rsmp      (pins_s.rsmp),
    .vsmp      (pins_s.vsmp),
    .int_pulse (int_pulse),
    .close     (clamp_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_pulse <= 1'b0;
      clamp_close  <= 1'b0;
    end else begin
      sample_pulse <= int_pulse;
      clamp_close  <= clamp_nxt;
    end
  end

endmodule

// File: rtl/pix_sample_timing_chk.sv
module pix_sample_timing_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic vsmp_pin,
  input logic rsmp_pin,
  input logic cfg_legacy,
  input logic cfg_det_en,
  input logic cfg_clamp_en,
  input logic cfg_clamp_and,
  input logic cfg_autocycle,
  input logic cfg_clamp_force,
  input logic sample_pulse,
  input logic clamp_close
);

  localparam int LAT = SYNC_STAGES + 1;

  // Cycles since reset, saturating at the pipeline latency
  logic [3:0] live_cnt;
  always_ff @(posedge clk) begin
    if (rst)                  live_cnt <= '0;
    else if (live_cnt < LAT)  live_cnt <= live_cnt + 4'd1;
  end

  logic warm;
  assign warm = (live_cnt >= LAT);

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!sample_pulse && !clamp_close)); // R1

  AST_PASS_VSMP: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!(cfg_legacy && cfg_det_en))) |-> (sample_pulse == $past(vsmp_pin, LAT))); // R2

  AST_CLAMP_RSMP: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!cfg_legacy && cfg_clamp_en && !cfg_autocycle && !cfg_clamp_and))
      |-> (clamp_close == $past(rsmp_pin, LAT))); // R7

  AST_CLAMP_AND: assert property (@(posedge clk) disable iff (rst)
    (warm && $past(!cfg_legacy && cfg_clamp_en && !cfg_autocycle && cfg_clamp_and))
      |-> (clamp_close == ($past(rsmp_pin, LAT) && $past(vsmp_pin, LAT)))); // R8

  AST_CLAMP_REG: assert property (@(posedge clk) disable iff (rst)
    (live_cnt != 4'd0 && $past(!cfg_legacy && cfg_clamp_en && cfg_autocycle))
      |-> (clamp_close == $past(cfg_clamp_force))); // R9

  AST_CLAMP_OFF: assert property (@(posedge clk) disable iff (rst)
    (live_cnt != 4'd0 && $past(!cfg_legacy && !cfg_clamp_en)) |-> !clamp_close); // R10

  AST_LEGACY_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (live_cnt != 4'd0 && $past(cfg_legacy)) |-> (clamp_close == sample_pulse)); // R11

endmodule

bind pix_sample_timing pix_sample_timing_chk #(
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .vsmp_pin        (vsmp_pin),
  .rsmp_pin        (rsmp_pin),
  .cfg_legacy      (cfg_legacy),
  .cfg_det_en      (cfg_det_en),
  .cfg_clamp_en    (cfg_clamp_en),
  .cfg_clamp_and   (cfg_clamp_and),
  .cfg_autocycle   (cfg_autocycle),
  .cfg_clamp_force (cfg_clamp_force),
  .sample_pulse    (sample_pulse),
  .clamp_close     (clamp_close)
);

// File: tb/test_pix_sample_timing.sv
module test_pix_sample_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vsmp_pin = 1'b0, rsmp_pin = 1'b0;
  logic       cfg_legacy = 1'b0, cfg_det_en = 1'b0, cfg_rise_sel = 1'b1;
  logic [2:0] cfg_delay = 3'd0;
  logic       cfg_clamp_en = 1'b1, cfg_clamp_and = 1'b0;
  logic       cfg_autocycle = 1'b0, cfg_clamp_force = 1'b0;
  logic       sample_pulse, clamp_close;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pix_sample_timing i_pix_sample_timing (
    .clk (clk), .rst (rst), .vsmp_pin (vsmp_pin), .rsmp_pin (rsmp_pin),
    .cfg_legacy (cfg_legacy), .cfg_det_en (cfg_det_en), .cfg_rise_sel (cfg_rise_sel),
    .cfg_delay (cfg_delay), .cfg_clamp_en (cfg_clamp_en), .cfg_clamp_and (cfg_clamp_and),
    .cfg_autocycle (cfg_autocycle), .cfg_clamp_force (cfg_clamp_force),
    .sample_pulse (sample_pulse), .clamp_close (clamp_close)
  );

  // Steady-state vectors:
  // {legacy, det, rise, clamp_en, and, auto, force, vsmp, rsmp, exp_pulse, exp_clamp}
  localparam logic [10:0] VEC [12] = '{
    11'b0_0_0_1_0_0_0_1_0_1_0, // R2 R7
    11'b0_0_0_1_0_0_0_0_1_0_1, // R7
    11'b0_0_1_1_1_0_0_0_1_0_0, // R8 R4
    11'b0_0_0_1_1_0_0_1_1_1_1, // R8
    11'b0_0_0_1_1_0_0_1_0_1_0, // R8
    11'b0_0_0_1_0_1_0_0_1_0_0, // R9 rsmp ignored
    11'b0_0_0_1_0_1_1_0_0_0_1, // R9
    11'b0_0_0_0_0_0_0_1_1_1_0, // R10
    11'b0_0_0_0_0_1_1_0_1_0_0, // R10
    11'b1_0_0_1_0_0_0_1_1_1_1, // R11 legacy without detect
    11'b1_1_1_0_0_0_0_1_1_0_0, // R3 steady pin, no pulse
    11'b0_1_1_1_0_0_0_1_0_1_0  // R2 detect bit alone
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply pin patterns one bit per cycle; record outputs at each falling edge
  task automatic run_pat(input logic [19:0] vpat, input logic [19:0] rpat,
                         output int pcnt, output int pfirst,
                         output int ccnt, output int cfirst);
    pcnt = 0; pfirst = -1; ccnt = 0; cfirst = -1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (sample_pulse) begin
        pcnt++;
        if (pfirst < 0) pfirst = j;
      end
      if (clamp_close) begin
        ccnt++;
        if (cfirst < 0) cfirst = j;
      end
      vsmp_pin = vpat[j];
      rsmp_pin = rpat[j];
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pc, pf, cc, cf;
    // R1: reset state
    idle(3);
    chk(!sample_pulse && !clamp_close, "R1 during reset", {sample_pulse, clamp_close}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sample_pulse && !clamp_close, "R1 after reset", {sample_pulse, clamp_close}, 0);

    // Vector table walk
    foreach (VEC[i]) begin
      @(negedge clk);
      {cfg_legacy, cfg_det_en, cfg_rise_sel, cfg_clamp_en, cfg_clamp_and,
       cfg_autocycle, cfg_clamp_force, vsmp_pin, rsmp_pin} = VEC[i][10:2];
      cfg_delay = 3'd0;
      idle(6);
      chk(sample_pulse == VEC[i][1], $sformatf("R2/R3 vec%0d pulse", i), sample_pulse, VEC[i][1]);
      chk(clamp_close == VEC[i][0], $sformatf("R7-R11 vec%0d clamp", i), clamp_close, VEC[i][0]);
    end

    // R2 / R7 latency in pass-through
    @(negedge clk);
    {cfg_legacy, cfg_det_en, cfg_clamp_en, cfg_clamp_and, cfg_autocycle} = 5'b00100;
    vsmp_pin = 0; rsmp_pin = 0;
    idle(5);
    run_pat(20'h0000E, 20'h00030, pc, pf, cc, cf);
    chk(pf == 4 && pc == 3, "R2 latency", pf, 4);
    chk(cf == 7 && cc == 2, "R7 latency", cf, 7);

    // R3 / R5: rising edge detect, delay 0
    {cfg_legacy, cfg_det_en, cfg_rise_sel} = 3'b111;
    cfg_clamp_en = 1'b0;
    cfg_delay = 3'd0;
    vsmp_pin = 0;
    idle(5);
    run_pat(20'hFFFFF, 20'h0, pc, pf, cc, cf);
    chk(pc == 1 && pf == 3, "R3 rising D=0", pf, 3);
    chk(cc == 1 && cf == 3, "R11 clamp with pulse", cf, 3);

    // R3: falling selected, rising ignored, then falling fires; D=5
    cfg_rise_sel = 1'b0;
    cfg_delay = 3'd5;
    vsmp_pin = 0;
    idle(12);
    run_pat(20'hFFFFF, 20'h0, pc, pf, cc, cf);
    chk(pc == 0, "R3 wrong polarity ignored", pc, 0);
    run_pat(20'h00000, 20'h0, pc, pf, cc, cf);
    chk(pc == 1 && pf == 8, "R5 falling D=5", pf, 8);

    // R5: delay 7
    cfg_rise_sel = 1'b1;
    cfg_delay = 3'd7;
    idle(4);
    run_pat(20'hFFFFF, 20'h0, pc, pf, cc, cf);
    chk(pc == 1 && pf == 10, "R5 rising D=7", pf, 10);

    // R6: retrigger restarts delay (edges at 0 and 2, D=4)
    vsmp_pin = 0;
    cfg_delay = 3'd4;
    idle(12);
    run_pat(20'hFFFFD, 20'h0, pc, pf, cc, cf);
    chk(pc == 1, "R6 single pulse", pc, 1);
    chk(pf == 9, "R6 restarted position", pf, 9);

    // R4: rise_sel flip in pass-through has no effect
    cfg_det_en = 1'b0;
    cfg_rise_sel = 1'b0;
    vsmp_pin = 0;
    idle(5);
    run_pat(20'h00006, 20'h0, pc, pf, cc, cf);
    chk(pc == 2 && pf == 4, "R4 polarity ignored", pf, 4);

    // R9: force bit drives clamp, one cycle latency, rsmp toggling ignored
    @(negedge clk);
    {cfg_legacy, cfg_clamp_en, cfg_autocycle, cfg_clamp_force} = 4'b0110;
    idle(5);
    run_pat(20'h0, 20'hAAAAA, pc, pf, cc, cf);
    chk(cc == 0, "R9 rsmp ignored", cc, 0);
    cfg_clamp_force = 1'b1;
    @(negedge clk);
    chk(clamp_close == 1'b1, "R9 force latency", clamp_close, 1);

    // R1: mid-run reset clears outputs
    vsmp_pin = 1;
    {cfg_autocycle, cfg_clamp_force} = 2'b01;
    idle(5);
    rst = 1'b1;
    @(negedge clk);
    chk(!sample_pulse && !clamp_close, "R1 reset mid-run", {sample_pulse, clamp_close}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sample_pulse, "R1 first cycle after reset", sample_pulse, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule